// File: doc/BRIEF.md
# Model-Specific Register Write Checker

This block takes one request to write a 64-bit model-specific register and settles it in a single clock cycle. The request carries a register index and two data halves, together with the current privilege level, the processor mode and a flag for a lock prefix. The block works out whether the write is legal. A legal write updates a small internal file of implemented registers and commits. An illegal write raises either a general protection fault or an invalid opcode fault, and it leaves the register file untouched.

Each register in the file is described by a compile-time table entry. An entry gives the register's index, a mask of reserved bits, a flag that makes the register hold only canonical linear addresses, and a flag that marks it as a memory-type range register. Besides the verdict, a committed write raises two one-cycle strobes. One asks for a full TLB invalidate, including global entries. The other asks for pipeline serialization. A separate combinational read port returns the stored value at any index, so a caller can inspect the file.

Top module: `msr_wr_guard`

## Requirements
- R1: A committed write stores `{req_hi[31:0], req_lo[31:0]}` into the selected register, so the high half lands in bits 63:32 and the low half in bits 31:0. The read port returns this value from the cycle after the request onward.
- R2: Bits 63:32 of `req_index`, `req_hi` and `req_lo` have no effect on the verdict, on the strobes or on the stored value.
- R3: When `req_lock` is 1, the response is the invalid opcode fault (`rsp_fault` = 2) and no register changes. This holds whatever the mode, privilege level, index or data.
- R4: In virtual-8086 mode (`req_mode` = 2), the response is a general protection fault (`rsp_fault` = 1) and no register changes.
- R5: In protected mode (`req_mode` = 1) or 64-bit mode (`req_mode` = 3), a privilege level other than 0 gives a general protection fault. In real-address mode (`req_mode` = 0), the privilege level is not checked.
- R6: An index that matches no implemented register gives a general protection fault and leaves every register unchanged. The read port returns 0 for such an index.
- R7: Data that sets any bit in the selected register's reserved mask gives a general protection fault, and the register keeps its old value.
- R8: For a register flagged as canonical, a value whose bits 63:47 are not all equal to bit 47 gives a general protection fault. A canonical value commits.
- R9: A committed write to a register flagged as a memory-type range register pulses `tlb_flush_all` for one cycle, together with the response. A fault never pulses it, and a write to any other register never pulses it.
- R10: Every committed write pulses `serialize_req`, except writes to index 0x6E0 and writes to indices 0x802 through 0x83F inclusive.
- R11: The response, its fault code and both strobes appear in the cycle after the request and last one cycle. When no request is given, `rsp_valid`, `rsp_commit` and both strobes stay at 0.
- R12: After reset, every register in the file reads 0 and all response outputs are 0.
- R13: When several fault conditions hold at once, the lock prefix is reported first, then mode and privilege, then the index, then the reserved-bit and canonical checks. The fault code is the one for the highest-ranked condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A write request is presented this cycle |
| req_index | input | 64 | Register index source; only bits 31:0 are used |
| req_hi | input | 64 | High data source; bits 31:0 become bits 63:32 of the value |
| req_lo | input | 64 | Low data source; bits 31:0 become bits 31:0 of the value |
| req_cpl | input | 2 | Current privilege level |
| req_mode | input | 2 | 0 real-address, 1 protected, 2 virtual-8086, 3 64-bit/compatibility |
| req_lock | input | 1 | Lock prefix present |
| rd_index | input | 32 | Index for the read port |
| rd_data | output | 64 | Stored value at `rd_index`, or 0 if that index is not implemented |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_commit | output | 1 | The write was performed |
| rsp_fault | output | 2 | 0 none, 1 general protection (error code 0), 2 invalid opcode |
| tlb_flush_all | output | 1 | One-cycle request to invalidate all TLB entries, including global ones |
| serialize_req | output | 1 | One-cycle request to serialize the pipeline |

## Verification
Every result is registered exactly once. The verdict, the fault code and both strobes are due one clock edge after the request is sampled, and the stored value is visible on the read port at that same edge. The bench therefore drives each request on a falling edge and removes it on the next falling edge. It then samples every output at that second falling edge, half a period after the rising edge that registered them. The bench checks the cycle after that as well, to confirm that each pulse has ended.

// File: rtl/msr_wr_pkg.sv
package msr_wr_pkg;

    localparam int IDX_W  = 32;
    localparam int HALF_W = 32;
    localparam int VAL_W  = 2 * HALF_W;

    typedef enum logic [1:0] {
        MODE_REAL = 2'd0,
        MODE_PROT = 2'd1,
        MODE_V86  = 2'd2,
        MODE_LONG = 2'd3
    } cpu_mode_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_GP   = 2'd1,
        FLT_UD   = 2'd2
    } fault_e;

    typedef struct packed {
        logic   valid;
        logic   commit;
        fault_e fault;
        logic   tlb_flush;
        logic   serialize;
    } rsp_t;

endpackage

// File: rtl/msr_table_lookup.sv
module msr_table_lookup
    import msr_wr_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter logic [N_ENT-1:0][IDX_W-1:0] ENT_INDEX = '0,
    parameter logic [N_ENT-1:0][VAL_W-1:0] ENT_RSVD  = '0,
    parameter logic [N_ENT-1:0]            ENT_CANON = '0,
    parameter logic [N_ENT-1:0]            ENT_MTRR  = '0
) (
    input  logic [IDX_W-1:0] index,
    output logic [N_ENT-1:0] sel,
    output logic             hit,
    output logic [VAL_W-1:0] rsvd_mask,
    output logic             canon_chk,
    output logic             is_mtrr
);

    for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
        assign sel[e] = (index == ENT_INDEX[e]);
    end

    always_comb begin
        rsvd_mask = '0;
        canon_chk = 1'b0;
        is_mtrr   = 1'b0;
        for (int e = 0; e < N_ENT; e++) begin
            rsvd_mask = rsvd_mask | (ENT_RSVD[e] & {VAL_W{sel[e]}});
            canon_chk = canon_chk | (ENT_CANON[e] & sel[e]);
            is_mtrr   = is_mtrr   | (ENT_MTRR[e]  & sel[e]);
        end
        hit = |sel;
    end

endmodule

// File: rtl/msr_fault_eval.sv
module msr_fault_eval
    import msr_wr_pkg::*;
#(
    parameter int VA_BITS = 48
) (
    input  logic             lock,
    input  cpu_mode_e        mode,
    input  logic [1:0]       cpl,
    input  logic             hit,
    input  logic [VAL_W-1:0] rsvd_mask,
    input  logic             canon_chk,
    input  logic [VAL_W-1:0] value,
    output fault_e           fault
);

    localparam int TOP_W = VAL_W - VA_BITS + 1;

    logic [TOP_W-1:0] top_bits;
    logic             canonical;
    logic             priv_bad;
    logic             rsvd_bad;
    logic             canon_bad;

    always_comb begin
        top_bits  = value[VAL_W-1:VA_BITS-1];
        canonical = (&top_bits) | ~(|top_bits);
        priv_bad  = (mode == MODE_V86) ||
                    ((mode != MODE_REAL) && (cpl != 2'd0));
        rsvd_bad  = |(value & rsvd_mask);
        canon_bad = canon_chk && !canonical;

        if (lock) begin
            fault = FLT_UD;
        end else if (priv_bad) begin
            fault = FLT_GP;
        end else if (!hit) begin
            fault = FLT_GP;
        end else if (rsvd_bad || canon_bad) begin
            fault = FLT_GP;
        end else begin
            fault = FLT_NONE;
        end
    end

endmodule

// File: rtl/msr_store.sv
module msr_store
    import msr_wr_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter logic [N_ENT-1:0][IDX_W-1:0] ENT_INDEX = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [N_ENT-1:0] wr_sel,
    input  logic [VAL_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_index,
    output logic [VAL_W-1:0] rd_data
);

    logic [N_ENT-1:0][VAL_W-1:0] mem_d;
    logic [N_ENT-1:0][VAL_W-1:0] mem_q;
    logic [N_ENT-1:0]            rd_hit;

    always_comb begin
        mem_d = mem_q;
        for (int e = 0; e < N_ENT; e++) begin
            if (wr_en && wr_sel[e]) begin
                mem_d[e] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar e = 0; e < N_ENT; e++) begin : g_rd
        assign rd_hit[e] = (rd_index == ENT_INDEX[e]);
    end

    always_comb begin
        rd_data = '0;
        for (int e = 0; e < N_ENT; e++) begin
            rd_data = rd_data | (mem_q[e] & {VAL_W{rd_hit[e]}});
        end
    end

endmodule

// File: rtl/msr_wr_guard.sv
module msr_wr_guard
    import msr_wr_pkg::*;
#(
    parameter int N_ENT   = 8,
    parameter int VA_BITS = 48,
    parameter logic [N_ENT-1:0][IDX_W-1:0] ENT_INDEX = {
        32'h0000_0175, 32'hC000_0082, 32'hC000_0100, 32'h0000_083F,
        32'h0000_06E0, 32'h0000_02FF, 32'h0000_0200, 32'h0000_0010},
    parameter logic [N_ENT-1:0][VAL_W-1:0] ENT_RSVD = {
        64'h0, 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FF00,
        64'h0, 64'hFFFF_FFFF_FFFF_F300, 64'hFFFF_FFF0_0000_0F00, 64'h0},
    parameter logic [N_ENT-1:0] ENT_CANON = 8'b1110_0000,
    parameter logic [N_ENT-1:0] ENT_MTRR  = 8'b0000_0110,
    parameter logic [IDX_W-1:0] SER_FREE_ONE = 32'h0000_06E0,
    parameter logic [IDX_W-1:0] SER_FREE_LO  = 32'h0000_0802,
    parameter logic [IDX_W-1:0] SER_FREE_HI  = 32'h0000_083F
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [63:0] req_index,
    input  logic [63:0] req_hi,
    input  logic [63:0] req_lo,
    input  logic [1:0]  req_cpl,
    input  logic [1:0]  req_mode,
    input  logic        req_lock,
    input  logic [31:0] rd_index,
    output logic [63:0] rd_data,
    output logic        rsp_valid,
    output logic        rsp_commit,
    output logic [1:0]  rsp_fault,
    output logic        tlb_flush_all,
    output logic        serialize_req
);

    logic [IDX_W-1:0] idx;
    logic [VAL_W-1:0] value;
    logic             unused_upper;

    assign idx          = req_index[IDX_W-1:0];
    assign value        = {req_hi[HALF_W-1:0], req_lo[HALF_W-1:0]};
    assign unused_upper = ^{req_index[63:IDX_W], req_hi[63:HALF_W], req_lo[63:HALF_W]};

    logic [N_ENT-1:0] sel;
    logic             hit;
    logic [VAL_W-1:0] rsvd_mask;
    logic             canon_chk;
    logic             is_mtrr;
    fault_e           fault;

    msr_table_lookup #(
        .N_ENT     (N_ENT),
        .ENT_INDEX (ENT_INDEX),
        .ENT_RSVD  (ENT_RSVD),
        .ENT_CANON (ENT_CANON),
        .ENT_MTRR  (ENT_MTRR)
    ) i_lookup (
        .index     (idx),
        .sel       (sel),
        .hit       (hit),
        .rsvd_mask (rsvd_mask),
        .canon_chk (canon_chk),
        .is_mtrr   (is_mtrr)
    );

    msr_fault_eval #(
        .VA_BITS (VA_BITS)
    ) i_fault (
        .lock      (req_lock),
        .mode      (cpu_mode_e'(req_mode)),
        .cpl       (req_cpl),
        .hit       (hit),
        .rsvd_mask (rsvd_mask),
        .canon_chk (canon_chk),
        .value     (value),
        .fault     (fault)
    );

    logic wr_en;
    logic ser_free;
    rsp_t rsp_d;
    rsp_t rsp_q;

    always_comb begin
        ser_free = (idx == SER_FREE_ONE) ||
                   ((idx >= SER_FREE_LO) && (idx <= SER_FREE_HI));
        wr_en    = req_valid && (fault == FLT_NONE);
        rsp_d    = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.fault = fault;
            if (fault == FLT_NONE) begin
                rsp_d.commit    = 1'b1;
                rsp_d.tlb_flush = is_mtrr;
                rsp_d.serialize = !ser_free;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    msr_store #(
        .N_ENT     (N_ENT),
        .ENT_INDEX (ENT_INDEX)
    ) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (sel),
        .wr_data  (value),
        .rd_index (rd_index),
        .rd_data  (rd_data)
    );

    assign rsp_valid     = rsp_q.valid;
    assign rsp_commit    = rsp_q.commit;
    assign rsp_fault     = rsp_q.fault;
    assign tlb_flush_all = rsp_q.tlb_flush;
    assign serialize_req = rsp_q.serialize;

endmodule

// File: rtl/msr_wr_guard_chk.sv
module msr_wr_guard_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  req_cpl,
    input logic [1:0]  req_mode,
    input logic        req_lock,
    input logic [31:0] rd_index,
    input logic [63:0] rd_data,
    input logic        rsp_valid,
    input logic        rsp_commit,
    input logic [1:0]  rsp_fault,
    input logic        tlb_flush_all,
    input logic        serialize_req
);

    AST_LOCK_UD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_lock) |=> (rsp_fault == 2'd2 && !rsp_commit)); // R3

    AST_V86_GP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_lock && req_mode == 2'd2) |=> (rsp_fault == 2'd1)); // R4

    AST_PRIV_GP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_lock && req_mode != 2'd0 && req_cpl != 2'd0)
        |=> (rsp_fault == 2'd1)); // R5

    AST_COMMIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_commit |-> (rsp_valid && rsp_fault == 2'd0)); // R13

    AST_TLB_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush_all |-> rsp_commit); // R9

    AST_SER_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        serialize_req |-> rsp_commit); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !tlb_flush_all && !serialize_req)); // R11

    AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsp_commit && $stable(rd_index)) |-> $stable(rd_data)); // R6

endmodule

bind msr_wr_guard msr_wr_guard_chk i_msr_wr_guard_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_cpl       (req_cpl),
    .req_mode      (req_mode),
    .req_lock      (req_lock),
    .rd_index      (rd_index),
    .rd_data       (rd_data),
    .rsp_valid     (rsp_valid),
    .rsp_commit    (rsp_commit),
    .rsp_fault     (rsp_fault),
    .tlb_flush_all (tlb_flush_all),
    .serialize_req (serialize_req)
);

// File: tb/test_msr_wr_guard.sv
module test_msr_wr_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_index = '0;
    logic [63:0] req_hi = '0;
    logic [63:0] req_lo = '0;
    logic [1:0]  req_cpl = '0;
    logic [1:0]  req_mode = '0;
    logic        req_lock = 1'b0;
    logic [31:0] rd_index = '0;
    logic [63:0] rd_data;
    logic        rsp_valid;
    logic        rsp_commit;
    logic [1:0]  rsp_fault;
    logic        tlb_flush_all;
    logic        serialize_req;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    msr_wr_guard i_msr_wr_guard (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_index     (req_index),
        .req_hi        (req_hi),
        .req_lo        (req_lo),
        .req_cpl       (req_cpl),
        .req_mode      (req_mode),
        .req_lock      (req_lock),
        .rd_index      (rd_index),
        .rd_data       (rd_data),
        .rsp_valid     (rsp_valid),
        .rsp_commit    (rsp_commit),
        .rsp_fault     (rsp_fault),
        .tlb_flush_all (tlb_flush_all),
        .serialize_req (serialize_req)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [1:0]  mode;
        logic [1:0]  cpl;
        logic        lock;
        logic [31:0] idx;
        logic [31:0] hi;
        logic [31:0] lo;
        logic [1:0]  fault;
        logic        ser;
        logic        tlb;
        logic [63:0] rd;
    } vec_t;

    localparam int NV = 21;
    // mode 0 real, 1 protected, 2 v86, 3 64-bit; fault 0 none, 1 GP, 2 UD
    localparam vec_t VECS [NV] = '{
        '{8'd1,  2'd1, 2'd0, 1'b0, 32'h10,       32'h1234_5678, 32'h9ABC_DEF0, 2'd0, 1'b1, 1'b0, 64'h1234_5678_9ABC_DEF0}, // R1
        '{8'd4,  2'd2, 2'd0, 1'b0, 32'h10,       32'h1,         32'h1,         2'd1, 1'b0, 1'b0, 64'h1234_5678_9ABC_DEF0}, // R4
        '{8'd5,  2'd1, 2'd3, 1'b0, 32'h10,       32'h0,         32'h5,         2'd1, 1'b0, 1'b0, 64'h1234_5678_9ABC_DEF0}, // R5
        '{8'd5,  2'd0, 2'd3, 1'b0, 32'h10,       32'h0,         32'h5,         2'd0, 1'b1, 1'b0, 64'h5},                   // R5
        '{8'd3,  2'd3, 2'd0, 1'b1, 32'h10,       32'h0,         32'h7,         2'd2, 1'b0, 1'b0, 64'h5},                   // R3
        '{8'd6,  2'd3, 2'd0, 1'b0, 32'h999,      32'h0,         32'h1,         2'd1, 1'b0, 1'b0, 64'h0},                   // R6
        '{8'd9,  2'd3, 2'd0, 1'b0, 32'h200,      32'h1,         32'h6,         2'd0, 1'b1, 1'b1, 64'h0000_0001_0000_0006}, // R9
        '{8'd7,  2'd3, 2'd0, 1'b0, 32'h200,      32'h10,        32'h0,         2'd1, 1'b0, 1'b0, 64'h0000_0001_0000_0006}, // R7
        '{8'd7,  2'd3, 2'd0, 1'b0, 32'h200,      32'h0,         32'h100,       2'd1, 1'b0, 1'b0, 64'h0000_0001_0000_0006}, // R7
        '{8'd8,  2'd3, 2'd0, 1'b0, 32'hC000_0100, 32'h0000_7FFF, 32'hFFFF_F000, 2'd0, 1'b1, 1'b0, 64'h0000_7FFF_FFFF_F000}, // R8
        '{8'd8,  2'd3, 2'd0, 1'b0, 32'hC000_0100, 32'h0000_8000, 32'h0,         2'd1, 1'b0, 1'b0, 64'h0000_7FFF_FFFF_F000}, // R8
        '{8'd8,  2'd3, 2'd0, 1'b0, 32'hC000_0100, 32'hFFFF_8000, 32'h0,         2'd0, 1'b1, 1'b0, 64'hFFFF_8000_0000_0000}, // R8
        '{8'd10, 2'd3, 2'd0, 1'b0, 32'h6E0,      32'h0,         32'h55,        2'd0, 1'b0, 1'b0, 64'h55},                  // R10
        '{8'd10, 2'd3, 2'd0, 1'b0, 32'h83F,      32'h0,         32'hAB,        2'd0, 1'b0, 1'b0, 64'hAB},                  // R10
        '{8'd7,  2'd3, 2'd0, 1'b0, 32'h83F,      32'h0,         32'h1AB,       2'd1, 1'b0, 1'b0, 64'hAB},                  // R7
        '{8'd9,  2'd3, 2'd0, 1'b0, 32'h2FF,      32'h0,         32'h6,         2'd0, 1'b1, 1'b1, 64'h6},                   // R9
        '{8'd13, 2'd1, 2'd3, 1'b0, 32'h999,      32'h0,         32'h0,         2'd1, 1'b0, 1'b0, 64'h0},                   // R13
        '{8'd13, 2'd2, 2'd3, 1'b1, 32'h10,       32'h0,         32'h0,         2'd2, 1'b0, 1'b0, 64'h5},                   // R13
        '{8'd8,  2'd3, 2'd0, 1'b0, 32'h175,      32'h0000_8000, 32'h0,         2'd1, 1'b0, 1'b0, 64'h0},                   // R8
        '{8'd13, 2'd1, 2'd0, 1'b1, 32'h2FF,      32'h0,         32'h100,       2'd2, 1'b0, 1'b0, 64'h6},                   // R13
        '{8'd6,  2'd0, 2'd0, 1'b0, 32'h999,      32'h0,         32'h0,         2'd1, 1'b0, 1'b0, 64'h0}                    // R6
    };

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] mode, input logic [1:0] cpl, input logic lock,
                        input logic [63:0] idx, input logic [63:0] hi, input logic [63:0] lo);
        req_mode  = mode;
        req_cpl   = cpl;
        req_lock  = lock;
        req_index = idx;
        req_hi    = hi;
        req_lo    = lo;
        rd_index  = idx[31:0];
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        rd_index = 32'h10;
        #1;
        check("R12", "rd_data in reset", rd_data, 64'h0);
        check("R12", "rsp_valid in reset", {63'h0, rsp_valid}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_index = 32'hC000_0100;
        #1;
        check("R12", "rd_data after reset", rd_data, 64'h0);
        check("R12", "strobes after reset", {62'h0, tlb_flush_all, serialize_req}, 64'h0);

        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[v].req);
            send(VECS[v].mode, VECS[v].cpl, VECS[v].lock,
                 {32'h0, VECS[v].idx}, {32'h0, VECS[v].hi}, {32'h0, VECS[v].lo});
            check(tag, $sformatf("vec %0d valid", v), {63'h0, rsp_valid}, 64'h1);
            check(tag, $sformatf("vec %0d fault", v), {62'h0, rsp_fault}, {62'h0, VECS[v].fault});
            check(tag, $sformatf("vec %0d commit", v), {63'h0, rsp_commit},
                  {63'h0, VECS[v].fault == 2'd0});
            check(tag, $sformatf("vec %0d serialize", v), {63'h0, serialize_req}, {63'h0, VECS[v].ser});
            check(tag, $sformatf("vec %0d tlb", v), {63'h0, tlb_flush_all}, {63'h0, VECS[v].tlb});
            check(tag, $sformatf("vec %0d rd_data", v), rd_data, VECS[v].rd);
        end

        // R2: upper source halves ignored
        send(2'd3, 2'd0, 1'b0, 64'hDEAD_BEEF_0000_06E0, 64'hFFFF_FFFF_0000_0001,
             64'hAAAA_AAAA_0000_0002);
        check("R2", "fault with junk upper bits", {62'h0, rsp_fault}, 64'h0);
        check("R2", "serialize exempt with junk index", {63'h0, serialize_req}, 64'h0);
        check("R2", "stored value", rd_data, 64'h0000_0001_0000_0002);

        // R11: one-cycle pulses, quiet when idle
        send(2'd0, 2'd2, 1'b0, 64'h200, 64'h0, 64'h5);
        check("R11", "pulse tlb", {63'h0, tlb_flush_all}, 64'h1);
        check("R1", "real mode write value", rd_data, 64'h5);
        @(negedge clk);
        check("R11", "valid dropped", {63'h0, rsp_valid}, 64'h0);
        check("R11", "tlb dropped", {63'h0, tlb_flush_all}, 64'h0);
        check("R11", "serialize dropped", {63'h0, serialize_req}, 64'h0);
        req_lock = 1'b1;
        req_mode = 2'd2;
        repeat (2) @(negedge clk);
        check("R11", "idle with lock held", {62'h0, rsp_fault}, 64'h0);
        check("R11", "idle commit", {63'h0, rsp_commit}, 64'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule